// File: doc/BRIEF.md
# Debug Communications Channel Mailbox

This block holds two single-word mailboxes between a processor core and an external debugger. One mailbox carries a word from the target to the host, which is the transmit direction. The other carries a word from the host to the target, which is the receive direction. Each mailbox has one full flag. Both flags appear together in one status word, and either side can read that status word.

The core side has a small operation port. In any cycle it does one of four things: idle, read status, write the transmit word, or read the receive word. The debugger side is a register port addressed by word index. Index 32 writes the receive word, index 34 reads the status word and index 35 reads the transmit word.

Read data on both ports is combinational from the current state. A flag that changes at a clock edge is seen by the very next access on either side, so no extra synchronisation cycle is needed. An access that finds its mailbox in the wrong state has a defined outcome. It is either dropped with the contents kept, or it returns zero without touching the flag.

Top module: `dcc_mailbox`

## Requirements
- R1: After reset both flags are 0 and both stored words are 0, so a status read from either side returns 0.
- R2: The status word carries the transmit-full flag at bit 29 and the receive-full flag at bit 30, and all other bits are 0. The core reads it with `core_op` = 2'b01, and the debugger reads it with a read of index 34. Both return the same value in the same cycle.
- R3: A core transmit write (`core_op` = 2'b10) while transmit-full is 0 stores `core_wdata` and sets transmit-full. The next access sees this.
- R4: A core transmit write while transmit-full is 1 is dropped. The stored word and the flag stay unchanged.
- R5: A debugger read of index 35 while transmit-full is 1 returns the stored word in that cycle and clears transmit-full.
- R6: A debugger read of index 35 while transmit-full is 0 leaves transmit-full at 0. The returned data is don't-care, and a later core transmit write still succeeds.
- R7: A debugger write of index 32 while receive-full is 0 stores `dbg_wdata` and sets receive-full.
- R8: A debugger write of index 32 while receive-full is 1 is dropped. The stored word and the flag stay unchanged.
- R9: A core receive read (`core_op` = 2'b11) while receive-full is 1 returns the stored word in that cycle and clears receive-full.
- R10: A core receive read while receive-full is 0 returns zero and leaves receive-full at 0.
- R11: When both sides act on the same mailbox in one cycle, each access is judged against the state before that edge. On an empty mailbox the fill takes effect and the drain is ignored. On a full mailbox the drain takes effect and the fill is dropped. A flag never sees a set and a clear together.
- R12: A debugger access to any other index reads zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_op | input | 2 | Core operation: 00 idle, 01 status read, 10 transmit write, 11 receive read |
| core_wdata | input | 32 | Word for a core transmit write |
| core_rdata | output | 32 | Core read data (status or receive word) |
| dbg_en | input | 1 | Debugger access strobe |
| dbg_we | input | 1 | Debugger access is a write |
| dbg_idx | input | 6 | Debugger register word index |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Debugger read data |

## Verification
The two sides can meet on one mailbox in the same cycle. A core transmit write can meet a debugger index-35 read, and a core receive read can meet a debugger index-32 write. Either pair may also coincide with a status read from the other side. The bench drives these pairs on purpose, in directed steps with the mailbox both empty and full, and then through a long stretch of random stimulus that mixes both ports every clock. A behavioural reference model judges every cycle. Its next state is taken only from the state before the edge, and it compares each port's read data in the cycle of the access, with later status reads confirming which side won.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
    localparam int DATA_W   = 32;
    localparam int IDX_W    = 6;
    localparam int TXF_POS  = 29;
    localparam int RXF_POS  = 30;
    localparam int IDX_RXWR = 32;
    localparam int IDX_STAT = 34;
    localparam int IDX_TXRD = 35;

    typedef enum logic [1:0] {
        CORE_IDLE = 2'b00,
        CORE_STAT = 2'b01,
        CORE_TXWR = 2'b10,
        CORE_RXRD = 2'b11
    } core_op_e;
endpackage

// File: rtl/dcc_slot.sv
module dcc_slot #(
    parameter int W = dcc_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         full,
    output logic [W-1:0] data
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] word;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.full && push) begin
            st_d.full = 1'b1;
            st_d.word = push_data;
        end else if (st_q.full && pop) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full = st_q.full;
    assign data = st_q.word;

    // R3 R7
    fill_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (full && data == $past(push_data)));
    // R4 R8
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (full && $stable(data)));
    // R5 R9
    drain_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && full) |=> !full);
    // R6 R10
    drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !full && !push) |=> (!full && $stable(data)));
endmodule

// File: rtl/dcc_core_port.sv
module dcc_core_port
    import dcc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   core_op,
    input  logic [W-1:0] core_wdata,
    input  logic         rx_full,
    input  logic [W-1:0] rx_data,
    input  logic [W-1:0] status,
    output logic         tx_push,
    output logic [W-1:0] tx_push_data,
    output logic         rx_pop,
    output logic [W-1:0] core_rdata
);
    core_op_e op;
    assign op = core_op_e'(core_op);

    always_comb begin
        tx_push      = 1'b0;
        rx_pop       = 1'b0;
        tx_push_data = core_wdata;
        core_rdata   = '0;
        unique case (op)
            CORE_STAT: core_rdata = status;
            CORE_TXWR: tx_push = 1'b1;
            CORE_RXRD: begin
                rx_pop     = 1'b1;
                core_rdata = rx_full ? rx_data : '0;
            end
            default: ;
        endcase
    end

    // R10
    rx_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == CORE_RXRD && !rx_full) |-> (core_rdata == '0));
endmodule

// File: rtl/dcc_dbg_port.sv
module dcc_dbg_port
    import dcc_pkg::*;
#(
    parameter int W        = DATA_W,
    parameter int AW       = IDX_W,
    parameter int I_RXWR   = IDX_RXWR,
    parameter int I_STAT   = IDX_STAT,
    parameter int I_TXRD   = IDX_TXRD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbg_en,
    input  logic          dbg_we,
    input  logic [AW-1:0] dbg_idx,
    input  logic [W-1:0]  dbg_wdata,
    input  logic          tx_full,
    input  logic [W-1:0]  tx_data,
    input  logic [W-1:0]  status,
    output logic          rx_push,
    output logic [W-1:0]  rx_push_data,
    output logic          tx_pop,
    output logic [W-1:0]  dbg_rdata
);
    localparam logic [AW-1:0] A_RXWR = AW'(I_RXWR);
    localparam logic [AW-1:0] A_STAT = AW'(I_STAT);
    localparam logic [AW-1:0] A_TXRD = AW'(I_TXRD);

    logic rd, wr;
    assign rd = dbg_en && !dbg_we;
    assign wr = dbg_en &&  dbg_we;

    always_comb begin
        rx_push      = wr && (dbg_idx == A_RXWR);
        rx_push_data = dbg_wdata;
        tx_pop       = rd && (dbg_idx == A_TXRD);
        dbg_rdata    = '0;
        if (rd) begin
            if (dbg_idx == A_STAT)                 dbg_rdata = status;
            else if (dbg_idx == A_TXRD && tx_full) dbg_rdata = tx_data;
        end
    end

    // R12
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && dbg_idx != A_STAT && dbg_idx != A_TXRD) |-> (dbg_rdata == '0));
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox
    import dcc_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int AW     = IDX_W,
    parameter int TXF    = TXF_POS,
    parameter int RXF    = RXF_POS,
    parameter int I_RXWR = IDX_RXWR,
    parameter int I_STAT = IDX_STAT,
    parameter int I_TXRD = IDX_TXRD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    core_op,
    input  logic [W-1:0]  core_wdata,
    output logic [W-1:0]  core_rdata,
    input  logic          dbg_en,
    input  logic          dbg_we,
    input  logic [AW-1:0] dbg_idx,
    input  logic [W-1:0]  dbg_wdata,
    output logic [W-1:0]  dbg_rdata
);
    logic         tx_push, tx_pop, tx_full;
    logic [W-1:0] tx_push_data, tx_data;
    logic         rx_push, rx_pop, rx_full;
    logic [W-1:0] rx_push_data, rx_data;
    logic [W-1:0] status;

    always_comb begin
        status      = '0;
        status[TXF] = tx_full;
        status[RXF] = rx_full;
    end

    dcc_slot #(.W(W)) i_tx_slot (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
        .full(tx_full), .data(tx_data)
    );

    dcc_slot #(.W(W)) i_rx_slot (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
        .full(rx_full), .data(rx_data)
    );

    dcc_core_port #(.W(W)) i_core_port (
        .clk(clk), .rst_n(rst_n),
        .core_op(core_op), .core_wdata(core_wdata),
        .rx_full(rx_full), .rx_data(rx_data), .status(status),
        .tx_push(tx_push), .tx_push_data(tx_push_data),
        .rx_pop(rx_pop), .core_rdata(core_rdata)
    );

    dcc_dbg_port #(.W(W), .AW(AW), .I_RXWR(I_RXWR), .I_STAT(I_STAT), .I_TXRD(I_TXRD)) i_dbg_port (
        .clk(clk), .rst_n(rst_n),
        .dbg_en(dbg_en), .dbg_we(dbg_we), .dbg_idx(dbg_idx), .dbg_wdata(dbg_wdata),
        .tx_full(tx_full), .tx_data(tx_data), .status(status),
        .rx_push(rx_push), .rx_push_data(rx_push_data),
        .tx_pop(tx_pop), .dbg_rdata(dbg_rdata)
    );

    // R2
    status_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_op == CORE_STAT && dbg_en && !dbg_we && dbg_idx == AW'(I_STAT))
        |-> (core_rdata == dbg_rdata));
    // R11
    tx_race_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_pop && tx_full) |=> !tx_full);
    // R11
    rx_race_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_pop && !rx_full) |=> (rx_full && rx_data == $past(dbg_wdata)));
endmodule

// File: tb/test_dcc_mailbox.sv
module test_dcc_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  core_op = 2'b00;
    logic [31:0] core_wdata = '0;
    logic [31:0] core_rdata;
    logic        dbg_en = 1'b0;
    logic        dbg_we = 1'b0;
    logic [5:0]  dbg_idx = '0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    bit          m_txf = 0, m_rxf = 0;
    logic [31:0] m_txd = '0, m_rxd = '0;

    always #10 clk = ~clk;

    dcc_mailbox i_dcc_mailbox (
        .clk(clk), .rst_n(rst_n),
        .core_op(core_op), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .dbg_en(dbg_en), .dbg_we(dbg_we), .dbg_idx(dbg_idx),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
    );

    function automatic logic [31:0] m_status();
        logic [31:0] s = '0;
        s[29] = m_txf;
        s[30] = m_rxf;
        return s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [31:0] cw,
                        input logic de, input logic dw, input logic [5:0] di,
                        input logic [31:0] dwd, input string lab);
        string t;
        bit n_txf, n_rxf;
        logic [31:0] n_txd, n_rxd;
        @(negedge clk);
        core_op = op; core_wdata = cw;
        dbg_en = de; dbg_we = dw; dbg_idx = di; dbg_wdata = dwd;
        #2;
        if (op == 2'b01) begin
            t = (lab != "") ? lab : "R2";
            chk({t, " core status"}, core_rdata, m_status());
        end else if (op == 2'b11) begin
            t = (lab != "") ? lab : (m_rxf ? "R9" : "R10");
            chk({t, " core rx read"}, core_rdata, m_rxf ? m_rxd : 32'h0);
        end
        if (de && !dw) begin
            if (di == 6'd34) begin
                t = (lab != "") ? lab : "R2";
                chk({t, " dbg status"}, dbg_rdata, m_status());
            end else if (di == 6'd35) begin
                if (m_txf) begin
                    t = (lab != "") ? lab : "R5";
                    chk({t, " dbg tx read"}, dbg_rdata, m_txd);
                end
            end else begin
                t = (lab != "") ? lab : "R12";
                chk({t, " dbg unmapped read"}, dbg_rdata, 32'h0);
            end
        end
        @(posedge clk);
        n_txf = m_txf; n_rxf = m_rxf; n_txd = m_txd; n_rxd = m_rxd;
        if (op == 2'b10 && !m_txf) begin n_txf = 1; n_txd = cw; end
        if (de && !dw && di == 6'd35 && m_txf) n_txf = 0;
        if (de && dw && di == 6'd32 && !m_rxf) begin n_rxf = 1; n_rxd = dwd; end
        if (op == 2'b11 && m_rxf) n_rxf = 0;
        m_txf = n_txf; m_rxf = n_rxf; m_txd = n_txd; m_rxd = n_rxd;
    endtask

    task automatic idle_stat(input string lab);
        step(2'b01, 0, 1, 0, 6'd34, 0, lab);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state from both sides
        idle_stat("R1");
        step(2'b11, 0, 1, 0, 6'd35, 0, "R1");
        // R3 core fill, then R4 drop
        step(2'b10, 32'hCAFE_0001, 0, 0, 0, 0, "R3");
        idle_stat("R3");
        step(2'b10, 32'h1111_2222, 0, 0, 0, 0, "R4");
        idle_stat("R4");
        // R5 debugger drain returns first word, flag clears
        step(2'b00, 0, 1, 0, 6'd35, 0, "R5");
        idle_stat("R5");
        // R6 read of empty transmit is ignored, then core fill still works
        step(2'b00, 0, 1, 0, 6'd35, 0, "R6");
        idle_stat("R6");
        step(2'b10, 32'h0BAD_F00D, 0, 0, 0, 0, "R6");
        step(2'b00, 0, 1, 0, 6'd35, 0, "R6");
        // R7 debugger fill, R8 drop
        step(2'b00, 0, 1, 1, 6'd32, 32'hDEAD_BEEF, "R7");
        idle_stat("R7");
        step(2'b00, 0, 1, 1, 6'd32, 32'h5555_AAAA, "R8");
        idle_stat("R8");
        // R9 core drain returns kept word
        step(2'b11, 0, 0, 0, 0, 0, "R9");
        idle_stat("R9");
        // R10 empty core read returns zero, flag unchanged
        step(2'b11, 0, 0, 0, 0, 0, "R10");
        idle_stat("R10");
        // R12 unmapped write then read
        step(2'b00, 0, 1, 1, 6'd33, 32'hFFFF_FFFF, "R12");
        step(2'b00, 0, 1, 0, 6'd33, 0, "R12");
        idle_stat("R12");
        // R11 same-cycle races, empty then full
        step(2'b10, 32'h1234_5678, 1, 0, 6'd35, 0, "R11");
        idle_stat("R11");
        step(2'b10, 32'h8765_4321, 1, 0, 6'd35, 0, "R11");
        idle_stat("R11");
        step(2'b11, 0, 1, 1, 6'd32, 32'hA5A5_0000, "R11");
        idle_stat("R11");
        step(2'b11, 0, 1, 1, 6'd32, 32'h0000_5A5A, "R11");
        idle_stat("R11");
        // R2 mixed random traffic, model compared every cycle
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] di;
            int pick = $urandom_range(0, 7);
            di = (pick < 3) ? 6'd32 : (pick < 5) ? 6'd34 : (pick < 7) ? 6'd35 : 6'($urandom);
            step(2'($urandom), $urandom, 1'($urandom), 1'($urandom), di, $urandom, "");
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule